// File: doc/BRIEF.md
# Echo Channel Path State Controller

This block governs how a single voice channel's two PCM streams move through an echo-cancelling path. The send stream either carries the canceller's processed sample or the raw input, and the receive stream passes straight through. Each direction can be forced to the zero code. The block also decides when the adaptive filter may adapt. Host control bits set a base mode. A qualified disable tone seen in either direction can push the channel out of adaptation into bypass without any host action. That forced bypass is held until the line has been quiet for a programmable number of frames.

The tone detectors and the adaptive filter are outside the block and appear only as flag inputs and a processed-sample input. A tone-rule selector picks one of two qualification rules. Under the permissive rule, a tone flag alone is enough. Under the strict rule, a phase reversal must also be flagged. The rule applies to both directions. Tone indications leave the block on active-low pins. A power-down input silences the channel: the PCM outputs are released, the pins are driven high and the tone hold is cleared. All control outputs are registered and change one clock after the inputs that cause them. The PCM data paths are combinational through the registered selects.

Top module: `echo_path_ctrl`

## Requirements
- R1: While rst_n is low, chan_state is 0 (off), both output enables are 0, both PCM outputs are 0, adapt_en is 0 and both tone pins are 1.
- R2: One clock after pwr_n is sampled low, chan_state is 0, snd_oe and rcv_oe are 0, snd_out and rcv_out are 0, adapt_en and offset_en are 0, and td_snd_n and td_rcv_n are 1. This holds whatever the other inputs are.
- R3: With pwr_n high, the chan_state reported one clock later follows a fixed priority. It is 1 (mute) if either mute bit is set. Otherwise it is 2 (bypass) if bypass_bit is set or a tone bypass is held. Otherwise it is 3 (frozen) if adapt_off_bit is set. Otherwise it is 4 (adapt).
- R4: mute_snd_bit forces snd_out to 0 and mute_rcv_bit forces rcv_out to 0. Each bit acts only on its own direction, and its output enable stays 1.
- R5: When unmuted, snd_out equals snd_in while a bypass (register or tone) is in force and equals snd_proc otherwise. When unmuted, rcv_out equals rcv_in in every powered state.
- R6: adapt_en is 1 exactly when chan_state is 4.
- R7: A tone in a direction is valid when its tone flag is set and either rule_any_tone is 1 or that direction's phase-reversal flag is set. td_snd_n and td_rcv_n go to 0 one clock after a valid tone in their direction, in any powered mode, whether tone_auto is set or not.
- R8: With tone_auto set, a valid tone in either direction while the control bits select adapt moves the channel to bypass one clock later. A tone seen while the bits select frozen, bypass or mute does not start a hold. With tone_auto clear, tones never change chan_state.
- R9: A held tone bypass is released, returning to adapt, at the Nth frame_tick that has no valid tone since the hold began or since the last valid tone, where N is hold_frames and N = 0 counts as 1. A valid tone in any cycle restarts the count.
- R10: A frame_tick that arrives in the same cycle as a valid tone counts as tone, not quiet: the hold continues and the count restarts.
- R11: offset_en is 1 one clock after pwr_n high with offset_off_bit clear, in every mode, and 0 otherwise.
- R12: Clearing tone_auto, or a cycle with pwr_n low, drops a held tone bypass, so the channel returns to the mode selected by the bits alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_n | input | 1 | Power-down, active low |
| frame_tick | input | 1 | One-cycle pulse per PCM frame |
| mute_snd_bit | input | 1 | Zero the send output |
| mute_rcv_bit | input | 1 | Zero the receive output |
| bypass_bit | input | 1 | Host-requested bypass |
| adapt_off_bit | input | 1 | Freeze adaptation |
| offset_off_bit | input | 1 | Disable offset nulling |
| tone_auto | input | 1 | 1: tones force bypass internally; 0: report only |
| rule_any_tone | input | 1 | 1: tone flag alone qualifies; 0: phase reversal also needed |
| tone_snd | input | 1 | Tone present on send side |
| tone_rcv | input | 1 | Tone present on receive side |
| phrev_snd | input | 1 | Phase reversal seen on send side |
| phrev_rcv | input | 1 | Phase reversal seen on receive side |
| hold_frames | input | HOLD_W | Quiet frames needed to release a tone bypass |
| snd_in | input | DATA_W | Raw send sample |
| snd_proc | input | DATA_W | Echo-cancelled send sample |
| rcv_in | input | DATA_W | Receive sample |
| snd_out | output | DATA_W | Send output sample |
| rcv_out | output | DATA_W | Receive output sample |
| snd_oe | output | 1 | Send output driven |
| rcv_oe | output | 1 | Receive output driven |
| adapt_en | output | 1 | Adaptive filter may adapt |
| offset_en | output | 1 | Offset null filters active |
| td_snd_n | output | 1 | Send-side tone indication, active low |
| td_rcv_n | output | 1 | Receive-side tone indication, active low |
| chan_state | output | 3 | 0 off, 1 mute, 2 bypass, 3 frozen, 4 adapt |

## Verification
The release of a tone hold and the arrival of a new valid tone can fall in the same cycle: a frame_tick is the one that would complete the quiet count, yet a tone flag is also raised. The bench latches a hold with hold_frames of 2 and gives one quiet tick. It then raises a tick and a tone together and checks that the channel is still in bypass. Release is then expected only after two further quiet ticks, and the state is checked after each one. A mute written while a tone is present is also swept, and the check expects mute with no hold left behind once the mute clears.

// File: rtl/echo_path_pkg.sv
// Shared types for the echo channel path controller.
// Assumes: state codes are visible to software and must stay fixed.
package echo_path_pkg;

    typedef enum logic [2:0] {
        MODE_OFF    = 3'd0,
        MODE_MUTE   = 3'd1,
        MODE_BYPASS = 3'd2,
        MODE_FROZEN = 3'd3,
        MODE_ADAPT  = 3'd4
    } chan_mode_e;

    // Registered path controls produced by the mode decoder
    typedef struct packed {
        chan_mode_e mode;
        logic       live;
        logic       snd_zero;
        logic       rcv_zero;
        logic       snd_raw;
        logic       offset_on;
    } path_ctrl_t;

    localparam int NUM_DIR = 2;
    localparam int DIR_SND = 0;
    localparam int DIR_RCV = 1;

endpackage

// File: rtl/tone_qualifier.sv
// Qualifies per-direction disable-tone flags against the selected rule
// and drives registered active-low indication pins.
// Assumes: flags are already synchronous to clk; pins read high when
// the channel is powered down or in reset.
module tone_qualifier #(
    parameter int NDIR = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_n,
    input  logic            rule_any,
    input  logic [NDIR-1:0] tone_flag,
    input  logic [NDIR-1:0] phrev_flag,
    output logic [NDIR-1:0] tone_valid,
    output logic [NDIR-1:0] td_pin_n
);

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        logic td_q;

        // Rule check: permissive rule needs only the tone flag
        assign tone_valid[d] = tone_flag[d] & (rule_any | phrev_flag[d]);

        // Indication register, cleared in reset and power-down
        always_ff @(posedge clk) begin
            if (!rst_n)      td_q <= 1'b0;
            else if (!pwr_n) td_q <= 1'b0;
            else             td_q <= tone_valid[d];
        end

        assign td_pin_n[d] = ~td_q;
    end

endmodule

// File: rtl/bypass_hold.sv
// Holds a tone-forced bypass and counts quiet frames until release.
// Assumes: frame_tick is a single-cycle pulse; hold count 0 acts as 1.
// The quiet counter runs only while a hold is active.
module bypass_hold #(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_n,
    input  logic              tone_auto,
    input  logic              tone_any,
    input  logic              frame_tick,
    input  logic              base_adapt,
    input  logic [HOLD_W-1:0] hold_frames,
    output logic              hold_nx,
    output logic              hold_q
);

    localparam int CNT_W = HOLD_W + 1;

    logic [HOLD_W-1:0] cnt_q;
    logic [CNT_W-1:0]  cnt_inc;
    logic              reach;
    logic              drop_all;

    assign cnt_inc  = {1'b0, cnt_q} + CNT_W'(1);
    assign reach    = cnt_inc >= {1'b0, hold_frames};
    assign drop_all = ~pwr_n | ~tone_auto;

    // Next hold value: tone beats a completing quiet tick
    always_comb begin
        if (drop_all)        hold_nx = 1'b0;
        else if (hold_q) begin
            if (tone_any)                hold_nx = 1'b1;
            else if (frame_tick && reach) hold_nx = 1'b0;
            else                         hold_nx = 1'b1;
        end
        else                 hold_nx = tone_any & base_adapt;
    end

    // Hold flag register
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold_nx;
    end

    // Quiet-frame counter, restarted by any valid tone
    always_ff @(posedge clk) begin
        if (!rst_n)                                  cnt_q <= '0;
        else if (drop_all || tone_any || !hold_q)    cnt_q <= '0;
        else if (frame_tick)                         cnt_q <= reach ? '0 : cnt_inc[HOLD_W-1:0];
    end

endmodule

// File: rtl/mode_decoder.sv
// Resolves the channel mode by fixed priority and registers the path
// controls: off, then mute, then bypass, then frozen, then adapt.
// Assumes: control bits are static register outputs sampled each clock.
module mode_decoder
    import echo_path_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_n,
    input  logic       mute_snd_bit,
    input  logic       mute_rcv_bit,
    input  logic       bypass_bit,
    input  logic       adapt_off_bit,
    input  logic       offset_off_bit,
    input  logic       tone_hold,
    output logic       base_adapt,
    output path_ctrl_t ctrl_q
);

    path_ctrl_t ctrl_d;
    logic       any_mute;
    logic       any_bypass;

    assign any_mute   = mute_snd_bit | mute_rcv_bit;
    assign any_bypass = bypass_bit | tone_hold;
    assign base_adapt = ~(any_mute | bypass_bit | adapt_off_bit);

    // Priority decode of the next mode and path selects
    always_comb begin
        ctrl_d = '0;
        ctrl_d.mode = MODE_OFF;
        if (pwr_n) begin
            ctrl_d.live      = 1'b1;
            ctrl_d.snd_zero  = mute_snd_bit;
            ctrl_d.rcv_zero  = mute_rcv_bit;
            ctrl_d.snd_raw   = any_bypass;
            ctrl_d.offset_on = ~offset_off_bit;
            if (any_mute)           ctrl_d.mode = MODE_MUTE;
            else if (any_bypass)    ctrl_d.mode = MODE_BYPASS;
            else if (adapt_off_bit) ctrl_d.mode = MODE_FROZEN;
            else                    ctrl_d.mode = MODE_ADAPT;
        end
    end

    // Control register, reset to the off state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            ctrl_q.mode <= MODE_OFF;
        end
        else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/pcm_path_mux.sv
// Steers PCM samples by the registered path controls.
// Assumes: a released output is modelled by oe low with zero data.
module pcm_path_mux #(
    parameter int DATA_W = 16
) (
    input  logic              live,
    input  logic              snd_zero,
    input  logic              rcv_zero,
    input  logic              snd_raw,
    input  logic [DATA_W-1:0] snd_in,
    input  logic [DATA_W-1:0] snd_proc,
    input  logic [DATA_W-1:0] rcv_in,
    output logic [DATA_W-1:0] snd_out,
    output logic [DATA_W-1:0] rcv_out,
    output logic              snd_oe,
    output logic              rcv_oe
);

    // Send path: zero, raw or processed sample
    always_comb begin
        if (!live || snd_zero) snd_out = '0;
        else if (snd_raw)      snd_out = snd_in;
        else                   snd_out = snd_proc;
    end

    // Receive path: zero or pass-through
    always_comb begin
        if (!live || rcv_zero) rcv_out = '0;
        else                   rcv_out = rcv_in;
    end

    assign snd_oe = live;
    assign rcv_oe = live;

endmodule

// File: rtl/echo_path_ctrl.sv
// Per-channel path state controller for an echo-cancelling voice path.
// Combines host bits, qualified disable tones and power-down into a
// registered mode and steers the send and receive PCM streams.
// Assumes: all inputs synchronous to clk; one clock of control latency.
module echo_path_ctrl
    import echo_path_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_n,
    input  logic              frame_tick,
    input  logic              mute_snd_bit,
    input  logic              mute_rcv_bit,
    input  logic              bypass_bit,
    input  logic              adapt_off_bit,
    input  logic              offset_off_bit,
    input  logic              tone_auto,
    input  logic              rule_any_tone,
    input  logic              tone_snd,
    input  logic              tone_rcv,
    input  logic              phrev_snd,
    input  logic              phrev_rcv,
    input  logic [HOLD_W-1:0] hold_frames,
    input  logic [DATA_W-1:0] snd_in,
    input  logic [DATA_W-1:0] snd_proc,
    input  logic [DATA_W-1:0] rcv_in,
    output logic [DATA_W-1:0] snd_out,
    output logic [DATA_W-1:0] rcv_out,
    output logic              snd_oe,
    output logic              rcv_oe,
    output logic              adapt_en,
    output logic              offset_en,
    output logic              td_snd_n,
    output logic              td_rcv_n,
    output logic [2:0]        chan_state
);

    logic [NUM_DIR-1:0] tone_valid;
    logic [NUM_DIR-1:0] td_pin_n;
    logic               tone_any;
    logic               hold_nx;
    logic               hold_q;
    logic               base_adapt;
    path_ctrl_t         ctrl_q;

    tone_qualifier #(.NDIR(NUM_DIR)) u_tone (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_n      (pwr_n),
        .rule_any   (rule_any_tone),
        .tone_flag  ({tone_rcv, tone_snd}),
        .phrev_flag ({phrev_rcv, phrev_snd}),
        .tone_valid (tone_valid),
        .td_pin_n   (td_pin_n)
    );

    assign tone_any = |tone_valid;

    bypass_hold #(.HOLD_W(HOLD_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_n       (pwr_n),
        .tone_auto   (tone_auto),
        .tone_any    (tone_any),
        .frame_tick  (frame_tick),
        .base_adapt  (base_adapt),
        .hold_frames (hold_frames),
        .hold_nx     (hold_nx),
        .hold_q      (hold_q)
    );

    mode_decoder u_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwr_n          (pwr_n),
        .mute_snd_bit   (mute_snd_bit),
        .mute_rcv_bit   (mute_rcv_bit),
        .bypass_bit     (bypass_bit),
        .adapt_off_bit  (adapt_off_bit),
        .offset_off_bit (offset_off_bit),
        .tone_hold      (hold_nx),
        .base_adapt     (base_adapt),
        .ctrl_q         (ctrl_q)
    );

    pcm_path_mux #(.DATA_W(DATA_W)) u_mux (
        .live     (ctrl_q.live),
        .snd_zero (ctrl_q.snd_zero),
        .rcv_zero (ctrl_q.rcv_zero),
        .snd_raw  (ctrl_q.snd_raw),
        .snd_in   (snd_in),
        .snd_proc (snd_proc),
        .rcv_in   (rcv_in),
        .snd_out  (snd_out),
        .rcv_out  (rcv_out),
        .snd_oe   (snd_oe),
        .rcv_oe   (rcv_oe)
    );

    assign chan_state = ctrl_q.mode;
    assign adapt_en   = (ctrl_q.mode == MODE_ADAPT);
    assign offset_en  = ctrl_q.offset_on;
    assign td_snd_n   = td_pin_n[DIR_SND];
    assign td_rcv_n   = td_pin_n[DIR_RCV];

endmodule

// File: rtl/echo_path_ctrl_chk.sv
// Temporal checks on the path controller, bound to its ports.
// Assumes: all controls reach the outputs one clock after sampling.
module echo_path_ctrl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_n,
    input logic              mute_snd_bit,
    input logic              mute_rcv_bit,
    input logic              bypass_bit,
    input logic              adapt_off_bit,
    input logic              offset_off_bit,
    input logic              tone_auto,
    input logic              rule_any_tone,
    input logic              tone_snd,
    input logic              tone_rcv,
    input logic              phrev_snd,
    input logic [DATA_W-1:0] snd_out,
    input logic [DATA_W-1:0] rcv_out,
    input logic              snd_oe,
    input logic              rcv_oe,
    input logic              adapt_en,
    input logic              offset_en,
    input logic              td_snd_n,
    input logic              td_rcv_n,
    input logic [2:0]        chan_state
);

    // R2
    pwrdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(pwr_n)) |->
        (!snd_oe && !rcv_oe && td_snd_n && td_rcv_n && chan_state == 3'd0));

    // R4
    snd_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && pwr_n && mute_snd_bit) |-> (snd_out == '0 && snd_oe));

    // R4
    rcv_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && pwr_n && mute_rcv_bit) |-> (rcv_out == '0 && rcv_oe));

    // R6
    adapt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && adapt_en) |->
        $past(pwr_n && !mute_snd_bit && !mute_rcv_bit && !bypass_bit && !adapt_off_bit));

    // R8
    auto_tone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && pwr_n && tone_auto && tone_snd && (rule_any_tone || phrev_snd))
        |-> !adapt_en);

    // R7
    td_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && pwr_n && tone_rcv && rule_any_tone) |-> !td_rcv_n);

    // R11
    offset_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && pwr_n && !offset_off_bit) |-> offset_en);

endmodule

bind echo_path_ctrl echo_path_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pwr_n          (pwr_n),
    .mute_snd_bit   (mute_snd_bit),
    .mute_rcv_bit   (mute_rcv_bit),
    .bypass_bit     (bypass_bit),
    .adapt_off_bit  (adapt_off_bit),
    .offset_off_bit (offset_off_bit),
    .tone_auto      (tone_auto),
    .rule_any_tone  (rule_any_tone),
    .tone_snd       (tone_snd),
    .tone_rcv       (tone_rcv),
    .phrev_snd      (phrev_snd),
    .snd_out        (snd_out),
    .rcv_out        (rcv_out),
    .snd_oe         (snd_oe),
    .rcv_oe         (rcv_oe),
    .adapt_en       (adapt_en),
    .offset_en      (offset_en),
    .td_snd_n       (td_snd_n),
    .td_rcv_n       (td_rcv_n),
    .chan_state     (chan_state)
);

// File: tb/echo_path_ctrl_tb.sv
// Self-checking bench: sweeps control bits and tone patterns, then
// walks tone-hold release timing for several hold counts.
module echo_path_ctrl_tb;

    localparam int DATA_W = 16;
    localparam int HOLD_W = 4;

    localparam logic [2:0] S_OFF = 3'd0, S_MUTE = 3'd1, S_BYP = 3'd2,
                           S_FRZ = 3'd3, S_ADP = 3'd4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pwr_n = 1'b1;
    logic              frame_tick = 1'b0;
    logic              mute_snd_bit = 1'b0, mute_rcv_bit = 1'b0;
    logic              bypass_bit = 1'b0, adapt_off_bit = 1'b0, offset_off_bit = 1'b0;
    logic              tone_auto = 1'b0, rule_any_tone = 1'b0;
    logic              tone_snd = 1'b0, tone_rcv = 1'b0, phrev_snd = 1'b0, phrev_rcv = 1'b0;
    logic [HOLD_W-1:0] hold_frames = '0;
    logic [DATA_W-1:0] snd_in = 16'h1111, snd_proc = 16'h2222, rcv_in = 16'h3333;
    logic [DATA_W-1:0] snd_out, rcv_out;
    logic              snd_oe, rcv_oe, adapt_en, offset_en, td_snd_n, td_rcv_n;
    logic [2:0]        chan_state;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    echo_path_ctrl #(.DATA_W(DATA_W), .HOLD_W(HOLD_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .frame_tick(frame_tick),
        .mute_snd_bit(mute_snd_bit), .mute_rcv_bit(mute_rcv_bit),
        .bypass_bit(bypass_bit), .adapt_off_bit(adapt_off_bit),
        .offset_off_bit(offset_off_bit), .tone_auto(tone_auto),
        .rule_any_tone(rule_any_tone), .tone_snd(tone_snd), .tone_rcv(tone_rcv),
        .phrev_snd(phrev_snd), .phrev_rcv(phrev_rcv), .hold_frames(hold_frames),
        .snd_in(snd_in), .snd_proc(snd_proc), .rcv_in(rcv_in),
        .snd_out(snd_out), .rcv_out(rcv_out), .snd_oe(snd_oe), .rcv_oe(rcv_oe),
        .adapt_en(adapt_en), .offset_en(offset_en), .td_snd_n(td_snd_n),
        .td_rcv_n(td_rcv_n), .chan_state(chan_state)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock, then sample 1 ns after the edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_bits();
        mute_snd_bit = 0; mute_rcv_bit = 0; bypass_bit = 0;
        adapt_off_bit = 0; offset_off_bit = 0;
        tone_snd = 0; tone_rcv = 0; phrev_snd = 0; phrev_rcv = 0;
        frame_tick = 0; pwr_n = 1;
    endtask

    // Latch a tone hold from adapt using a permissive send-side tone
    task automatic latch_hold(input int n);
        clear_bits();
        tone_auto = 1; rule_any_tone = 1;
        hold_frames = HOLD_W'(n);
        step();
        chk("R8 pre adapt", chan_state, S_ADP);
        tone_snd = 1;
        step();
        chk("R8 tone forces bypass", chan_state, S_BYP);
        chk("R8 bypass send path", snd_out, snd_in);
        chk("R8 adapt off in hold", adapt_en, 0);
        tone_snd = 0;
    endtask

    task automatic quiet_tick();
        frame_tick = 1;
        step();
        frame_tick = 0;
    endtask

    initial begin
        // R1 reset state
        step(); step();
        chk("R1 state", chan_state, S_OFF);
        chk("R1 oe", {snd_oe, rcv_oe}, 2'b00);
        chk("R1 data", {snd_out, rcv_out}, 32'h0);
        chk("R1 adapt", adapt_en, 0);
        chk("R1 pins", {td_snd_n, td_rcv_n}, 2'b11);
        rst_n = 1;

        // R3 R4 R5 R6 R11: sweep of the five control bits
        for (int c = 0; c < 32; c++) begin
            logic [2:0] es;
            logic [DATA_W-1:0] eso, ero;
            mute_snd_bit = c[0]; mute_rcv_bit = c[1]; bypass_bit = c[2];
            adapt_off_bit = c[3]; offset_off_bit = c[4];
            snd_in = DATA_W'(16'h1000 + c); snd_proc = DATA_W'(16'h2000 + c);
            rcv_in = DATA_W'(16'h3000 + c);
            step();
            es = (c[0] | c[1]) ? S_MUTE : c[2] ? S_BYP : c[3] ? S_FRZ : S_ADP;
            eso = c[0] ? '0 : (c[2] ? snd_in : snd_proc);
            ero = c[1] ? '0 : rcv_in;
            chk("R3 priority state", chan_state, es);
            chk("R4 R5 send out", snd_out, eso);
            chk("R4 R5 recv out", rcv_out, ero);
            chk("R4 oe kept", {snd_oe, rcv_oe}, 2'b11);
            chk("R6 adapt strobe", adapt_en, es == S_ADP);
            chk("R11 offset", offset_en, !c[4]);
        end

        // R2 power-down over bit and tone patterns
        for (int c = 0; c < 16; c++) begin
            pwr_n = 0; mute_snd_bit = c[0]; bypass_bit = c[1];
            tone_snd = c[2]; tone_rcv = c[3]; rule_any_tone = 1; tone_auto = 1;
            offset_off_bit = 0;
            step();
            chk("R2 state", chan_state, S_OFF);
            chk("R2 oe", {snd_oe, rcv_oe}, 2'b00);
            chk("R2 data", {snd_out, rcv_out}, 32'h0);
            chk("R2 pins", {td_snd_n, td_rcv_n}, 2'b11);
            chk("R2 adapt offset", {adapt_en, offset_en}, 2'b00);
        end
        clear_bits(); tone_auto = 0;
        step();

        // R7 R8 external mode: qualification sweep, state stays adapt
        for (int c = 0; c < 32; c++) begin
            logic vs, vr;
            rule_any_tone = c[0]; tone_snd = c[1]; phrev_snd = c[2];
            tone_rcv = c[3]; phrev_rcv = c[4];
            vs = c[1] & (c[0] | c[2]);
            vr = c[3] & (c[0] | c[4]);
            step();
            chk("R7 send pin", td_snd_n, !vs);
            chk("R7 recv pin", td_rcv_n, !vr);
            chk("R8 external no force", chan_state, S_ADP);
        end
        clear_bits();

        // R7 strict rule in auto mode: tone without reversal is ignored
        tone_auto = 1; rule_any_tone = 0; tone_rcv = 1;
        step();
        chk("R7 strict no pin", td_rcv_n, 1);
        chk("R7 strict no force", chan_state, S_ADP);
        phrev_rcv = 1;
        step();
        chk("R7 strict pin", td_rcv_n, 0);
        chk("R8 recv tone forces", chan_state, S_BYP);
        clear_bits(); tone_auto = 0;
        step();
        chk("R12 auto off drops hold", chan_state, S_ADP);

        // R8 tone in frozen does not start a hold
        tone_auto = 1; rule_any_tone = 1; adapt_off_bit = 1; tone_snd = 1;
        step();
        chk("R8 frozen with tone", chan_state, S_FRZ);
        chk("R7 pin in frozen", td_snd_n, 0);
        tone_snd = 0; step();
        adapt_off_bit = 0; step();
        chk("R8 frozen left no hold", chan_state, S_ADP);

        // R3 R10 mute with tone: mute wins, no hold left behind
        mute_rcv_bit = 1; tone_snd = 1;
        step();
        chk("R3 mute over tone", chan_state, S_MUTE);
        tone_snd = 0; step();
        mute_rcv_bit = 0; step();
        chk("R3 no hold after mute", chan_state, S_ADP);

        // R9 release after N quiet ticks, N = 0..4
        for (int n = 0; n < 5; n++) begin
            int eff;
            eff = (n == 0) ? 1 : n;
            latch_hold(n);
            for (int k = 1; k <= eff; k++) begin
                step();
                chk("R9 hold between ticks", chan_state, S_BYP);
                quiet_tick();
                chk("R9 release timing", chan_state, (k == eff) ? S_ADP : S_BYP);
            end
        end

        // R9 tone mid-count restarts the count (N = 3)
        latch_hold(3);
        quiet_tick(); quiet_tick();
        tone_rcv = 1; step(); tone_rcv = 0;
        chk("R9 restart hold", chan_state, S_BYP);
        quiet_tick(); quiet_tick();
        chk("R9 restart partial", chan_state, S_BYP);
        quiet_tick();
        chk("R9 restart release", chan_state, S_ADP);

        // R10 tone on the completing tick (N = 2)
        latch_hold(2);
        quiet_tick();
        chk("R10 first quiet", chan_state, S_BYP);
        tone_snd = 1; quiet_tick(); tone_snd = 0;
        chk("R10 tone wins tick", chan_state, S_BYP);
        quiet_tick();
        chk("R10 recount one", chan_state, S_BYP);
        quiet_tick();
        chk("R10 recount release", chan_state, S_ADP);

        // R12 power-down drops a held bypass
        latch_hold(4);
        pwr_n = 0; step();
        chk("R12 pd state", chan_state, S_OFF);
        pwr_n = 1; step();
        chk("R12 pd drops hold", chan_state, S_ADP);

        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule